// File: doc/BRIEF.md
# Early-Evaluation Two-Way Elastic Selector

This block is a two-way multiplexer for a synchronous elastic pipeline, of the kind that picks the next fetch address from either a sequential increment or a branch target. It has three input channels (a one-bit pick channel and two data channels, A and B) and one output channel. Every channel carries a forward handshake: valid from the producer, stop from the consumer. The output fires as soon as the pick token and the data token it names are both present. The data channel that was not named does not have to be present.

The skipped channel still owes one token for that pick. The block pays the debt with anti-tokens. Each data channel has a small saturating counter of anti-tokens waiting to be paid. A token that arrives on a channel whose counter is non-zero is swallowed. It is never delivered, and the counter drops by one. A waiting anti-token is also offered backward to the upstream buffer on a separate backward handshake (anti-valid out, anti-stop in). If upstream accepts it, the counter drops by one as well. Seen as token streams, the output always equals, for the k-th pick token, the k-th token of the channel it names.

Top module: `early_eval_mux`

## Requirements
- R1: While reset is held, and right after it, both anti-token counters are zero. Neither `a_anti_valid` nor `b_anti_valid` is high, and `out_valid` stays low while no pick token is present.
- R2: `out_valid` is high when `sel_valid` is high, the channel named by `sel_pick` (0 names A, 1 names B) has a token with no pending anti-token, and the other channel's counter is not full. `out_data` is then that channel's data. The other channel's token is not needed.
- R3: In a cycle where the output fires (`out_valid` high and `out_stop` low), `sel_stop` and the named channel's stop are low. While `out_stop` is high nothing is consumed, and the output stays valid with the same data.
- R4: If the channel that was not named holds a live token when the output fires, that token is consumed in the same cycle and no anti-token is recorded for it.
- R5: If the channel that was not named has no token when the output fires, its counter goes up by one, and its anti-valid line is high from the next cycle on.
- R6: A token that arrives on a channel with a pending anti-token is consumed (stop low) and is never delivered to the output. The counter goes down by one, and both disappear.
- R7: A pending anti-token is offered upstream on the anti-valid line only while the channel has no token. It is removed in a cycle where the anti-stop input is low.
- R8: Each counter saturates at `MAX_ANTI`. While the counter of the channel that would be skipped is full, the block does not fire: `out_valid` is low and nothing is consumed. It fires again once that counter has drained.
- R9: When the named channel has pending anti-tokens, its arriving tokens are cancelled first. The output fires only on the first token that arrives after its counter reaches zero.
- R10: Under any pattern of arrival, backpressure and backward acceptance, the k-th output token equals the k-th token of the channel named by the k-th pick token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_valid | input | 1 | Pick token present |
| sel_pick | input | 1 | 0 names channel A, 1 names channel B |
| sel_stop | output | 1 | Pick token not consumed this cycle |
| a_valid | input | 1 | Channel A token present |
| a_data | input | WIDTH | Channel A data |
| a_stop | output | 1 | Channel A token not consumed this cycle |
| a_anti_valid | output | 1 | Anti-token offered upstream on channel A |
| a_anti_stop | input | 1 | Upstream refuses the channel A anti-token |
| b_valid | input | 1 | Channel B token present |
| b_data | input | WIDTH | Channel B data |
| b_stop | output | 1 | Channel B token not consumed this cycle |
| b_anti_valid | output | 1 | Anti-token offered upstream on channel B |
| b_anti_stop | input | 1 | Upstream refuses the channel B anti-token |
| out_valid | output | 1 | Output token present |
| out_data | output | WIDTH | Output data |
| out_stop | input | 1 | Downstream refuses the output token |

## Verification
The bench targets these cases:
- A late token meeting a pending anti-token. A block that passed it on would emit a stale value and shift every later pair of pick and data out of step.
- A counter at saturation. A block that fired anyway would wrap the counter and lose a debt.
- A named channel that still owes anti-tokens. A block that delivered its first arriving token would emit the cancelled value.
- A randomized run with backpressure and upstream anti-token acceptance, compared against a per-pick stream reference. This exposes any missing or doubled decrement, because the streams then fall out of alignment.

// File: rtl/eem_pkg.sv
package eem_pkg;

    // Which data channel a pick token names.
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    // Width of a counter that must hold values 0..max_cnt.
    function automatic int cnt_width(input int max_cnt);
        return (max_cnt < 1) ? 1 : $clog2(max_cnt + 1);
    endfunction

    // Combine one optional increment and one optional decrement.
    function automatic int unsigned step_count(input int unsigned cur,
                                               input logic up,
                                               input logic down);
        return cur + (up ? 1 : 0) - (down ? 1 : 0);
    endfunction

endpackage

// File: rtl/eem_anti_lane.sv
module eem_anti_lane #(
    parameter int MAX_ANTI = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tok_valid,   // forward token present
    input  logic anti_stop,   // upstream refuses the anti-token
    input  logic fire,        // the selector fires this cycle
    input  logic chosen,      // this lane is the one named by the pick
    output logic live,        // token present and not owed to an anti-token
    output logic full,        // counter saturated
    output logic take,        // token consumed this cycle
    output logic anti_valid   // anti-token offered upstream
);
    import eem_pkg::*;

    localparam int CW = cnt_width(MAX_ANTI);
    localparam logic [CW-1:0] FULL_V = CW'(MAX_ANTI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_d;
    logic pend, kill, inc, dec;

    assign pend       = (cnt != '0);
    assign live       = tok_valid && !pend;
    assign kill       = tok_valid && pend;
    assign full       = (cnt == FULL_V);
    assign anti_valid = pend && !tok_valid;

    // Consumed either by annihilation or by a firing selector.
    assign take = kill || (fire && live);
    // Skipped without a token to drop: record a debt.
    assign inc  = fire && !chosen && !live;
    assign dec  = kill || (anti_valid && !anti_stop);

    always_comb begin
        cnt_d = CW'(step_count(int'(cnt), inc, dec));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

    // R1: counter clear after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt == '0));

    // R5 / R8: a debt is only recorded below saturation
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (fire && !chosen && !live) |-> (cnt != FULL_V));

    // R6: a cancelled token is never the delivered one
    a_r6_no_deliver: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && pend) |-> !(fire && chosen));

    // R6: token and anti-token vanish together
    a_r6_annihilate: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && pend && !inc) |=> (cnt == $past(cnt) - 1'b1));

    // R7: accepted anti-token leaves the counter
    a_r7_drain: assert property (@(posedge clk) disable iff (rst)
        (anti_valid && !anti_stop && !inc) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/eem_fire_ctl.sv
module eem_fire_ctl (
    input  logic           sel_valid,
    input  eem_pkg::pick_e pick,
    input  logic           live_a,
    input  logic           live_b,
    input  logic           full_a,
    input  logic           full_b,
    input  logic           out_stop,
    output logic           out_valid,
    output logic           fire,
    output logic           chosen_a,
    output logic           chosen_b
);
    import eem_pkg::*;

    logic need_live;
    logic other_full;

    assign chosen_a   = (pick == PICK_A);
    assign chosen_b   = (pick == PICK_B);
    assign need_live  = chosen_a ? live_a : live_b;
    assign other_full = chosen_a ? full_b : full_a;

    assign out_valid = sel_valid && need_live && !other_full;
    assign fire      = out_valid && !out_stop;

endmodule

// File: rtl/eem_route.sv
module eem_route #(
    parameter int WIDTH = 16
) (
    input  eem_pkg::pick_e   pick,
    input  logic [WIDTH-1:0] data_a,
    input  logic [WIDTH-1:0] data_b,
    output logic [WIDTH-1:0] data_o
);
    import eem_pkg::*;

    always_comb begin
        unique case (pick)
            PICK_A:  data_o = data_a;
            default: data_o = data_b;
        endcase
    end

endmodule

// File: rtl/early_eval_mux.sv
module early_eval_mux #(
    parameter int WIDTH    = 16,
    parameter int MAX_ANTI = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_valid,
    input  logic             sel_pick,
    output logic             sel_stop,
    input  logic             a_valid,
    input  logic [WIDTH-1:0] a_data,
    output logic             a_stop,
    output logic             a_anti_valid,
    input  logic             a_anti_stop,
    input  logic             b_valid,
    input  logic [WIDTH-1:0] b_data,
    output logic             b_stop,
    output logic             b_anti_valid,
    input  logic             b_anti_stop,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_stop
);
    import eem_pkg::*;

    localparam int LANES = 2;

    pick_e pick;
    logic  fire;
    logic [LANES-1:0] tok_v, a_stp, chosen, live, full, take, anti_v;

    assign pick     = pick_e'(sel_pick);
    assign tok_v    = {b_valid, a_valid};
    assign a_stp    = {b_anti_stop, a_anti_stop};

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            eem_anti_lane #(.MAX_ANTI(MAX_ANTI)) u_lane (
                .clk       (clk),
                .rst       (rst),
                .tok_valid (tok_v[i]),
                .anti_stop (a_stp[i]),
                .fire      (fire),
                .chosen    (chosen[i]),
                .live      (live[i]),
                .full      (full[i]),
                .take      (take[i]),
                .anti_valid(anti_v[i])
            );
        end
    endgenerate

    eem_fire_ctl u_fire (
        .sel_valid(sel_valid),
        .pick     (pick),
        .live_a   (live[0]),
        .live_b   (live[1]),
        .full_a   (full[0]),
        .full_b   (full[1]),
        .out_stop (out_stop),
        .out_valid(out_valid),
        .fire     (fire),
        .chosen_a (chosen[0]),
        .chosen_b (chosen[1])
    );

    eem_route #(.WIDTH(WIDTH)) u_route (
        .pick  (pick),
        .data_a(a_data),
        .data_b(b_data),
        .data_o(out_data)
    );

    assign sel_stop     = !fire;
    assign a_stop       = !take[0];
    assign b_stop       = !take[1];
    assign a_anti_valid = anti_v[0];
    assign b_anti_valid = anti_v[1];

    // R3: a refused output token is held, unchanged, next cycle
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stop) |=> (out_valid && $stable(out_data)));

    // R3: a firing cycle consumes the pick token
    a_r3_pick_taken: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_stop) |-> !sel_stop);

endmodule

// File: tb/early_eval_mux_tb.sv
module early_eval_mux_tb;

    localparam int W = 16;
    localparam int M = 3;
    localparam int N = 200;

    logic clk = 1'b0;
    logic rst;
    logic sel_valid, sel_pick, sel_stop;
    logic a_valid, a_stop, a_anti_valid, a_anti_stop;
    logic b_valid, b_stop, b_anti_valid, b_anti_stop;
    logic [W-1:0] a_data, b_data, out_data;
    logic out_valid, out_stop;

    always #10 clk = ~clk;   // 50 MHz

    early_eval_mux #(.WIDTH(W), .MAX_ANTI(M)) u_dut (
        .clk(clk), .rst(rst),
        .sel_valid(sel_valid), .sel_pick(sel_pick), .sel_stop(sel_stop),
        .a_valid(a_valid), .a_data(a_data), .a_stop(a_stop),
        .a_anti_valid(a_anti_valid), .a_anti_stop(a_anti_stop),
        .b_valid(b_valid), .b_data(b_data), .b_stop(b_stop),
        .b_anti_valid(b_anti_valid), .b_anti_stop(b_anti_stop),
        .out_valid(out_valid), .out_data(out_data), .out_stop(out_stop)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit rnd_on = 0;
    int got = 0;
    logic [W-1:0] expq[$];
    logic [W-1:0] exp_item;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Drive one cycle of inputs at the falling edge and let them settle.
    task automatic drive(input logic sv, input logic sp,
                         input logic av, input logic [W-1:0] ad,
                         input logic bv, input logic [W-1:0] bd,
                         input logic ost, input logic ast, input logic bst);
        @(negedge clk);
        sel_valid = sv; sel_pick = sp;
        a_valid = av; a_data = ad;
        b_valid = bv; b_data = bd;
        out_stop = ost; a_anti_stop = ast; b_anti_stop = bst;
        #1;
    endtask

    task automatic idle(input logic ast, input logic bst);
        drive(0, 0, 0, '0, 0, '0, 0, ast, bst);
    endtask

    task automatic push_expected(input logic [W-1:0] item);
        expq.push_back(item);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (rnd_on && out_valid && !out_stop) begin
            if (expq.size() == 0) begin
                chk(0, "R10 unexpected output", {16'h0, out_data}, 32'h0);
            end else begin
                exp_item = expq.pop_front();
                chk(out_data == exp_item, "R10 stream order",
                    {16'h0, out_data}, {16'h0, exp_item});
                got++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 32'h0, 32'h1);
        wrap_up();
    end

    initial begin
        bit sels[N];
        int ia, ib, is;
        bit pa, pb, ps, ta, tb, ts, xa, xb;

        rst = 1;
        sel_valid = 0; sel_pick = 0; a_valid = 0; a_data = '0;
        b_valid = 0; b_data = '0; out_stop = 0;
        a_anti_stop = 1; b_anti_stop = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: clean state after reset
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(a_anti_valid == 0 && b_anti_valid == 0, "R1 anti lines after reset",
            {a_anti_valid, b_anti_valid}, 0);

        // R2 / R3: fire with B absent
        drive(1, 0, 1, 16'h00A1, 0, '0, 0, 1, 1);
        chk(out_valid == 1, "R2 fires without B", out_valid, 1);
        chk(out_data == 16'h00A1, "R2 data from A", out_data, 16'h00A1);
        chk(sel_stop == 0 && a_stop == 0, "R3 inputs taken on fire",
            {sel_stop, a_stop}, 0);
        idle(1, 1);
        chk(b_anti_valid == 1, "R5 anti-token on B", b_anti_valid, 1);
        chk(a_anti_valid == 0, "R5 no anti-token on A", a_anti_valid, 0);

        // R6: late token on B annihilated
        drive(0, 0, 0, '0, 1, 16'h00B1, 0, 1, 1);
        chk(b_stop == 0, "R6 late token consumed", b_stop, 0);
        chk(out_valid == 0, "R6 late token not delivered", out_valid, 0);
        idle(1, 1);
        chk(b_anti_valid == 0, "R6 anti-token gone", b_anti_valid, 0);

        // R4: unselected live token dropped
        drive(1, 1, 1, 16'h00D1, 1, 16'h00C1, 0, 1, 1);
        chk(out_data == 16'h00C1, "R2 data from B", out_data, 16'h00C1);
        chk(a_stop == 0 && b_stop == 0, "R4 both tokens taken", {a_stop, b_stop}, 0);
        idle(1, 1);
        chk(a_anti_valid == 0 && b_anti_valid == 0, "R4 no debt recorded",
            {a_anti_valid, b_anti_valid}, 0);

        // R3: backpressure
        drive(1, 0, 1, 16'h00E1, 0, '0, 1, 1, 1);
        chk(out_valid == 1 && sel_stop == 1 && a_stop == 1, "R3 stalled by out_stop",
            {out_valid, sel_stop, a_stop}, 3'b111);
        drive(1, 0, 1, 16'h00E1, 0, '0, 1, 1, 1);
        chk(out_data == 16'h00E1 && out_valid == 1, "R3 output held", out_data, 16'h00E1);
        chk(b_anti_valid == 0, "R3 no debt while stalled", b_anti_valid, 0);
        drive(1, 0, 1, 16'h00E1, 0, '0, 0, 1, 1);
        chk(a_stop == 0, "R3 taken once released", a_stop, 0);
        idle(1, 1);
        chk(b_anti_valid == 1, "R5 debt after release", b_anti_valid, 1);

        // R7: upstream accepts the anti-token
        idle(1, 0);
        chk(b_anti_valid == 1, "R7 offered", b_anti_valid, 1);
        idle(1, 1);
        chk(b_anti_valid == 0, "R7 removed after acceptance", b_anti_valid, 0);

        // R8: saturate B counter
        for (int k = 0; k < M; k++) begin
            drive(1, 0, 1, 16'h00F0 + 16'(k), 0, '0, 0, 1, 1);
            chk(out_valid == 1, "R8 fires below limit", out_valid, 1);
        end
        drive(1, 0, 1, 16'h00F9, 0, '0, 0, 1, 1);
        chk(out_valid == 0, "R8 stall at saturation", out_valid, 0);
        chk(sel_stop == 1 && a_stop == 1, "R8 nothing consumed", {sel_stop, a_stop}, 2'b11);
        drive(1, 0, 1, 16'h00F9, 0, '0, 0, 1, 0);
        chk(out_valid == 0 && b_anti_valid == 1, "R8 still stalled while draining",
            {out_valid, b_anti_valid}, 2'b01);
        drive(1, 0, 1, 16'h00F9, 0, '0, 0, 1, 1);
        chk(out_valid == 1 && out_data == 16'h00F9, "R8 resumes after drain",
            out_data, 16'h00F9);
        for (int k = 0; k < M; k++) idle(1, 0);
        idle(1, 1);
        chk(b_anti_valid == 0, "R7 full drain", b_anti_valid, 0);

        // R9: named channel owes an anti-token
        drive(1, 1, 0, '0, 1, 16'h0061, 0, 1, 1);
        chk(out_data == 16'h0061, "R9 setup fire on B", out_data, 16'h0061);
        drive(1, 0, 1, 16'h0071, 0, '0, 0, 1, 1);
        chk(out_valid == 0, "R9 owed token not delivered", out_valid, 0);
        chk(a_stop == 0, "R9 owed token cancelled", a_stop, 0);
        drive(1, 0, 1, 16'h0072, 0, '0, 0, 1, 1);
        chk(out_valid == 1 && out_data == 16'h0072, "R9 next token delivered",
            out_data, 16'h0072);
        idle(1, 0);
        idle(1, 1);
        chk(a_anti_valid == 0 && b_anti_valid == 0, "R9 all debts settled",
            {a_anti_valid, b_anti_valid}, 0);

        // R10: randomized stream comparison
        rst = 1;
        idle(1, 1);
        idle(1, 1);
        rst = 0;
        for (int k = 0; k < N; k++) begin
            sels[k] = 1'($urandom % 2);
            push_expected(sels[k] ? (16'h2000 + 16'(k)) : (16'h1000 + 16'(k)));
        end
        rnd_on = 1;
        ia = 0; ib = 0; is = 0;
        pa = 0; pb = 0; ps = 0;
        ta = 0; tb = 0; ts = 0; xa = 0; xb = 0;
        while (got < N) begin
            @(negedge clk);
            if (ta) begin ia++; pa = 0; end
            if (tb) begin ib++; pb = 0; end
            if (ts) begin is++; ps = 0; end
            if (xa) ia++;
            if (xb) ib++;
            if (!pa && ia < N && ($urandom % 4) != 0) pa = 1;
            if (!pb && ib < N && ($urandom % 4) != 0) pb = 1;
            if (!ps && is < N && ($urandom % 3) != 0) ps = 1;
            a_valid = pa; a_data = 16'h1000 + 16'(ia);
            b_valid = pb; b_data = 16'h2000 + 16'(ib);
            sel_valid = ps; sel_pick = (is < N) ? sels[is] : 1'b0;
            out_stop = (($urandom % 4) == 0);
            a_anti_stop = (($urandom % 3) != 0);
            b_anti_stop = (($urandom % 3) != 0);
            #1;
            ta = a_valid && !a_stop;
            tb = b_valid && !b_stop;
            ts = sel_valid && !sel_stop;
            xa = a_anti_valid && !a_anti_stop;
            xb = b_anti_valid && !b_anti_stop;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R10 all outputs seen", expq.size(), 0);
        wrap_up();
    end

endmodule